// File: doc/BRIEF.md
# Serial Synthesizer Register Loader

This block receives 16-bit command words over a three-wire serial link (serial clock, data, active-low frame) and routes each completed word into the tuning register file of a direct digital synthesis core. The file holds one 16-bit control word, two 28-bit frequency tuning words and two 12-bit phase offset words. The outputs carry the register contents straight to the synthesis core.

Bits are shifted in MSB first on falling serial clock edges while the frame line is low. Each completed word is handed into the system clock domain through a toggle handshake that fires once per word. The two top bits of the word pick the destination.

A frequency word can be written in two ways. In paired mode, two consecutive frequency writes deliver the low half and then the high half. The target changes in a single cycle only when the second half lands. In split mode, a single write replaces either the upper or the lower 14 bits and leaves the other half alone.

Top module: `dds_serial_loader`

## Requirements
- R1: After reset, every output (control, both frequency words, both phase words) is zero.
- R2: A word is shifted in MSB first, one bit per falling serial clock edge, and only while the frame line is low. Raising the frame line before 16 bits have arrived discards the partial word, and the next word starts counting from its first bit.
- R3: A word whose bits 15:14 are 00 replaces the whole control output with the word. It also cancels any half-finished paired frequency load.
- R4: Address 01 targets frequency word 0 and address 10 targets frequency word 1. The 14-bit payload is bits 13:0.
- R5: When control bit 13 (pair mode) is 1, the first frequency write after a control write or after a completed pair is held back. The second frequency write loads {second payload, first payload} into the register addressed by the second write. No frequency output changes after the first write.
- R6: When control bit 13 is 0 and control bit 12 is 1, a frequency write replaces bits 27:14 of the target and keeps bits 13:0. When control bit 12 is 0, it replaces bits 13:0 and keeps bits 27:14.
- R7: Address 11 is a phase write. Bit 13 selects phase word 1 (1) or phase word 0 (0), and bits 11:0 are the new value.
- R8: A write changes only the register it addresses. Outputs change only in the system clock cycle after a completed word is handed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, data sampled on its falling edge |
| ser_din | input | 1 | Serial data, MSB first |
| ser_frame_n | input | 1 | Active-low word frame |
| ctrl_o | output | 16 | Control word |
| freq0_o | output | 28 | Frequency tuning word 0 |
| freq1_o | output | 28 | Frequency tuning word 1 |
| phase0_o | output | 12 | Phase offset word 0 |
| phase1_o | output | 12 | Phase offset word 1 |

## Verification
The bench builds the block with its default widths (16-bit words, 28-bit frequency and 12-bit phase registers) and a two-stage synchronizer. At these widths each address code and both frequency update modes can be reached directly from the serial pins. A long pseudo-random word stream switches pair and split modes back and forth through control writes. A bench model computes the register file arithmetically after every word, so interleavings of half-finished pairs, control writes and writes to both frequency registers are all compared. Separate directed cases cover a frame aborted mid-word and the one-cycle atomic update of a paired load.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;
   // command address codes carried in the top two bits of each word
   localparam logic [1:0] ADDR_CTRL  = 2'b00;
   localparam logic [1:0] ADDR_FREQ0 = 2'b01;
   localparam logic [1:0] ADDR_FREQ1 = 2'b10;
   localparam logic [1:0] ADDR_PHASE = 2'b11;
   // control word bit positions decoded by the register file
   localparam int CTL_PAIR_BIT  = 13;
   localparam int CTL_UPPER_BIT = 12;
   // phase write: destination select bit
   localparam int PH_SEL_BIT    = 13;
endpackage

// File: rtl/dds_ser_shift.sv
module dds_ser_shift #(
   parameter int WORD_W = 16
) (
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              ser_frame_n,
   output logic [WORD_W-1:0] word_hold,
   output logic              word_tgl
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-2:0] shift_q;

   // frame high clears the bit count at once, so a partial word is lost
   always_ff @(negedge ser_clk or posedge ser_frame_n or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         shift_q   <= '0;
         word_hold <= '0;
         word_tgl  <= 1'b0;
      end else if (ser_frame_n) begin
         bit_cnt <= '0;
      end else if (bit_cnt == LAST) begin
         word_hold <= {shift_q, ser_din};
         word_tgl  <= ~word_tgl;
         bit_cnt   <= '0;
      end else begin
         shift_q <= {shift_q[WORD_W-3:0], ser_din};
         bit_cnt <= bit_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dds_tgl_sync.sv
module dds_tgl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic pulse
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= tgl_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];

   assign pulse = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/dds_reg_file.sv
module dds_reg_file
   import dds_loader_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int FREQ_W  = 28,
   parameter int PHASE_W = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [WORD_W-1:0]             word,
   output logic [WORD_W-1:0]             ctrl_q,
   output logic [1:0][FREQ_W-1:0]        freq_q,
   output logic [1:0][PHASE_W-1:0]       phase_q
);
   localparam int HALF_W = FREQ_W / 2;

   logic [1:0]        addr;
   logic [HALF_W-1:0] payload;
   logic              pair_mode;
   logic              upper_sel;
   logic              is_freq;
   logic              pend_q;
   logic [HALF_W-1:0] stage_q;

   assign addr      = word[WORD_W-1 -: 2];
   assign payload   = word[HALF_W-1:0];
   assign pair_mode = ctrl_q[CTL_PAIR_BIT];
   assign upper_sel = ctrl_q[CTL_UPPER_BIT];
   assign is_freq   = (addr == ADDR_FREQ0) || (addr == ADDR_FREQ1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         pend_q  <= 1'b0;
         stage_q <= '0;
      end else if (wr) begin
         if (addr == ADDR_CTRL) begin
            ctrl_q <= word;
            pend_q <= 1'b0;
         end else if (is_freq && pair_mode) begin
            if (!pend_q) stage_q <= payload;
            pend_q <= ~pend_q;
         end
      end
   end

   genvar k;
   generate
      for (k = 0; k < 2; k++) begin : g_freq
         localparam logic [1:0] MY_ADDR = 2'(k + 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               freq_q[k] <= '0;
            end else if (wr && addr == MY_ADDR) begin
               if (pair_mode) begin
                  if (pend_q) freq_q[k] <= {payload, stage_q};
               end else if (upper_sel) begin
                  freq_q[k][FREQ_W-1:HALF_W] <= payload;
               end else begin
                  freq_q[k][HALF_W-1:0] <= payload;
               end
            end
         end
      end
      for (k = 0; k < 2; k++) begin : g_phase
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q[k] <= '0;
            else if (wr && addr == ADDR_PHASE && word[PH_SEL_BIT] == 1'(k))
               phase_q[k] <= word[PHASE_W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader #(
   parameter int WORD_W      = 16,
   parameter int FREQ_W      = 28,
   parameter int PHASE_W     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_din,
   input  logic               ser_frame_n,
   output logic [WORD_W-1:0]  ctrl_o,
   output logic [FREQ_W-1:0]  freq0_o,
   output logic [FREQ_W-1:0]  freq1_o,
   output logic [PHASE_W-1:0] phase0_o,
   output logic [PHASE_W-1:0] phase1_o
);
   generate
      if (FREQ_W != 2 * (WORD_W - 2)) begin : g_bad_freq
         $error("FREQ_W must be two payloads of WORD_W-2 bits");
      end
      if (PHASE_W > WORD_W - 4) begin : g_bad_phase
         $error("PHASE_W must fit below the phase select bit");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0]        word_hold;
   logic                     word_tgl;
   logic                     word_vld;
   logic [1:0][FREQ_W-1:0]   freq_q;
   logic [1:0][PHASE_W-1:0]  phase_q;

   dds_ser_shift #(.WORD_W(WORD_W)) u_shift (
      .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ser_frame_n(ser_frame_n), .word_hold(word_hold), .word_tgl(word_tgl)
   );

   dds_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .tgl_in(word_tgl), .pulse(word_vld)
   );

   dds_reg_file #(.WORD_W(WORD_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(word_vld), .word(word_hold),
      .ctrl_q(ctrl_o), .freq_q(freq_q), .phase_q(phase_q)
   );

   assign freq0_o  = freq_q[0];
   assign freq1_o  = freq_q[1];
   assign phase0_o = phase_q[0];
   assign phase1_o = phase_q[1];
endmodule

// File: rtl/dds_loader_chk.sv
module dds_loader_chk #(
   parameter int WORD_W  = 16,
   parameter int FREQ_W  = 28,
   parameter int PHASE_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               word_vld,
   input logic [WORD_W-1:0]  word_hold,
   input logic [WORD_W-1:0]  ctrl_o,
   input logic [FREQ_W-1:0]  freq0_o,
   input logic [FREQ_W-1:0]  freq1_o,
   input logic [PHASE_W-1:0] phase0_o,
   input logic [PHASE_W-1:0] phase1_o
);
   localparam int HW = FREQ_W / 2;

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> ($stable(ctrl_o) && $stable(freq0_o) && $stable(freq1_o)
                     && $stable(phase0_o) && $stable(phase1_o)));

   // R3
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && word_hold[WORD_W-1 -: 2] == 2'b00) |=> (ctrl_o == $past(word_hold)));

   // R6
   split_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && word_hold[WORD_W-1 -: 2] == 2'b01 && !ctrl_o[13] && ctrl_o[12])
      |=> (freq0_o[HW-1:0] == $past(freq0_o[HW-1:0])
           && freq0_o[FREQ_W-1:HW] == $past(word_hold[HW-1:0])));

   // R7
   phase_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && word_hold[WORD_W-1 -: 2] == 2'b11)
      |=> (word_hold[13] ? $stable(phase0_o) : $stable(phase1_o)));

   // R8
   freq_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && word_hold[WORD_W-1 -: 2] != 2'b10) |=> $stable(freq1_o));
endmodule

bind dds_serial_loader dds_loader_chk #(.WORD_W(WORD_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_hold(word_hold),
   .ctrl_o(ctrl_o), .freq0_o(freq0_o), .freq1_o(freq1_o),
   .phase0_o(phase0_o), .phase1_o(phase1_o)
);

// File: tb/sim_dds_serial_loader.sv
`timescale 1ns/1ps
module sim_dds_serial_loader;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b1, ser_din = 1'b0, ser_frame_n = 1'b1;
   logic [15:0] ctrl_o;
   logic [27:0] freq0_o, freq1_o;
   logic [11:0] phase0_o, phase1_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [15:0] m_ctrl = '0;
   logic [27:0] m_f0 = '0, m_f1 = '0;
   logic [11:0] m_p0 = '0, m_p1 = '0;
   logic [13:0] m_stage = '0;
   logic        m_pend = 1'b0;

   always #4 clk = ~clk;

   dds_serial_loader u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ser_frame_n(ser_frame_n), .ctrl_o(ctrl_o), .freq0_o(freq0_o),
      .freq1_o(freq1_o), .phase0_o(phase0_o), .phase1_o(phase1_o)
   );

   task automatic check(input string req, input logic [27:0] got, input logic [27:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic shift_bits(input logic [15:0] w, input int nbits);
      ser_frame_n = 1'b0;
      #20;
      for (int i = 15; i > 15 - nbits; i--) begin
         ser_din = w[i];
         #32 ser_clk = 1'b0;
         #32 ser_clk = 1'b1;
      end
      #20 ser_frame_n = 1'b1;
      repeat (10) @(posedge clk);
      #2;
   endtask

   function automatic void model(input logic [15:0] w);
      case (w[15:14])
         2'b00: begin m_ctrl = w; m_pend = 1'b0; end
         2'b01, 2'b10: begin
            logic [27:0] r;
            r = (w[15:14] == 2'b01) ? m_f0 : m_f1;
            if (m_ctrl[13]) begin
               if (!m_pend) begin m_stage = w[13:0]; m_pend = 1'b1; end
               else begin r = {w[13:0], m_stage}; m_pend = 1'b0; end
            end else if (m_ctrl[12]) r[27:14] = w[13:0];
            else r[13:0] = w[13:0];
            if (w[15:14] == 2'b01) m_f0 = r; else m_f1 = r;
         end
         default: if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
      endcase
   endfunction

   task automatic send(input logic [15:0] w);
      shift_bits(w, 16);
      model(w);
   endtask

   task automatic check_all(input string req);
      check(req, {12'd0, ctrl_o}, {12'd0, m_ctrl});
      check(req, freq0_o, m_f0);
      check(req, freq1_o, m_f1);
      check(req, {16'd0, phase0_o}, {16'd0, m_p0});
      check(req, {16'd0, phase1_o}, {16'd0, m_p1});
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] lcg;
      repeat (5) @(posedge clk);
      #2 check_all("R1_reset");
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #2;

      // R3: control write
      send(16'h0ABC);
      check_all("R3_ctrl");

      // R6 split lower (ctrl bit12=0) on freq0, then upper (bit12=1) on freq1
      send(16'h4000 | 16'h1234);
      check_all("R6_lower");
      send(16'h1000);
      send(16'h8000 | 16'h2DEF);
      check_all("R6_upper");
      send(16'h4000 | 16'h3FFF);
      send(16'h0000);
      send(16'h4000 | 16'h0001);
      check("R6_keep_upper", freq0_o, {14'h3FFF, 14'h0001});

      // R5: paired load, first half leaves output untouched
      send(16'h2000);
      send(16'h4000 | 16'h0555);
      check("R5_first_half_held", freq0_o, {14'h3FFF, 14'h0001});
      send(16'h4000 | 16'h2AAA);
      check("R5_pair_done", freq0_o, {14'h2AAA, 14'h0555});
      // R4: pair finishing on freq1
      send(16'h4000 | 16'h0123);
      send(16'h8000 | 16'h0456);
      check_all("R4_pair_freq1");
      // R3: control write cancels a pending half
      send(16'h8000 | 16'h1111);
      send(16'h2000);
      send(16'h8000 | 16'h0777);
      check_all("R3_cancel_pending");

      // R7 phases
      send(16'hC000 | 16'h0ABC);
      send(16'hE000 | 16'h0123);
      check_all("R7_phase");

      // R2: aborted frame is discarded
      shift_bits(16'h3FFF, 9);
      check_all("R2_abort_ignored");
      send(16'h1001);
      check_all("R2_after_abort");

      // R8 pseudo-random sweep across all modes
      lcg = 32'h1357_9BDF;
      for (int i = 0; i < 300; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         send(lcg[31:16]);
         check_all("R8_sweep");
      end
      finish_run();
   end
endmodule